// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data-memory addresses for a processor datapath that walks delay lines and transform buffers. It keeps eight pointer sets in a primary bank and eight more in a secondary bank. Each set holds a current index, a signed step, a buffer length and a buffer start address. When an access is requested, the block returns an address taken from the chosen set. In post-step mode it returns the index and then advances it by the step. In pre-step mode it returns index plus step and leaves the index alone.

When the index is advanced, the block folds it back into the window that starts at the buffer's start address and spans its length. No software step is needed, and the window may begin at any address with no alignment. A length of zero turns the fold off and gives plain linear stepping. A bank-select input chooses which bank the access path uses, so each generator offers sixteen buffers. A small register port writes and reads every field of both banks. The address width is a parameter, so the same block serves 32-bit or 24-bit address spaces.

Top module: `circ_addr_gen`

## Requirements
- R1: Right after reset, addr_valid is 0, addr_out and reg_rdata are 0, every field of every set in both banks reads 0, and the primary bank is active.
- R2: A register write with reg_wr_en=1 stores reg_wdata into the field picked by reg_field (0 = index, 1 = step, 2 = length, 3 = start address), in the set picked by reg_set and the bank picked by reg_bank (0 = primary, 1 = secondary). A read with reg_rd_en=1 presents that field on reg_rdata one cycle later.
- R3: A post-step access (acc_req=1, acc_pre=0) puts the set's index on addr_out with addr_valid=1 in the next cycle, and the stored index becomes index plus step, folded per R5 to R7.
- R4: A pre-step access (acc_pre=1) puts index plus step (modulo 2^AW) on addr_out in the next cycle and leaves the stored index unchanged.
- R5: When length is non-zero and index plus step is at or above start plus length, the new index is index plus step minus length.
- R6: When length is non-zero and index plus step is below the start address, the new index is index plus step plus length. The step is a two's-complement value.
- R7: When length is zero, the new index is index plus step modulo 2^AW, with no folding.
- R8: bank_sel is registered. An access uses the bank that was selected on the previous cycle. Sets of the two banks are independent storage.
- R9: If a register write to the index of a set and a post-step access of that same set occur in the same cycle, the written value is kept. The access still returns the old index.
- R10: In a cycle without acc_req, addr_valid is 0 in the next cycle, addr_out keeps its value, and no index changes.
- R11: The window may start at any address, including one that is not a multiple of the length or of any power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 1 | Bank for accesses from the next cycle on: 0 primary, 1 secondary |
| acc_req | input | 1 | Access request |
| acc_set | input | 3 | Set used by the access |
| acc_pre | input | 1 | 1 = pre-step, 0 = post-step |
| addr_out | output | AW | Generated address, registered |
| addr_valid | output | 1 | addr_out holds a new address this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_bank | input | 1 | Bank addressed by the register port |
| reg_set | input | 3 | Set addressed by the register port |
| reg_field | input | 2 | Field: 0 index, 1 step, 2 length, 3 start |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Read data, one cycle after reg_rd_en |

## Verification
On every cycle, assertions check several timing and value rules. The valid flag must track the previous request. The active bank must follow the previous cycle's select. A post-step access must return the old index, and a pre-step access must return index plus step. Whenever a pointer starts inside its window and the step is no larger than the length, the folded pointer must land inside the window again. Only the bench scenarios can show the remaining behaviour: the exact folded values at both edges, an unaligned start address, linear wrap across the top of the address space, write-versus-update priority, and that idle cycles leave the stored index untouched.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    FLD_INDEX  = 2'd0,
    FLD_STEP   = 2'd1,
    FLD_LENGTH = 2'd2,
    FLD_START  = 2'd3
  } cag_field_e;
endpackage

// File: rtl/cag_fold.sv
// Adds a signed step to an index and folds the sum into [start, start+len).
module cag_fold #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] start,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  logic [EW-1:0] sum_e, start_e, len_e, lim_e, res_e;

  always_comb begin
    sum_e   = {2'b00, idx} + {{2{step[AW-1]}}, step};
    start_e = {2'b00, start};
    len_e   = {2'b00, len};
    lim_e   = start_e + len_e;
    if (len == '0)
      res_e = sum_e;
    else if ($signed(sum_e) >= $signed(lim_e))
      res_e = sum_e - len_e;
    else if ($signed(sum_e) < $signed(start_e))
      res_e = sum_e + len_e;
    else
      res_e = sum_e;
    nxt = res_e[AW-1:0];
  end
endmodule

// File: rtl/cag_regfile.sv
// Storage of both banks; register port write wins over an index update.
module cag_regfile
  import cag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_bank,
  input  logic [$clog2(NSETS)-1:0] wr_set,
  input  cag_field_e               wr_field,
  input  logic [AW-1:0]            wr_data,
  input  logic                     upd_en,
  input  logic                     upd_bank,
  input  logic [$clog2(NSETS)-1:0] upd_set,
  input  logic [AW-1:0]            upd_idx,
  input  logic                     cur_bank,
  input  logic [$clog2(NSETS)-1:0] cur_set,
  output logic [AW-1:0]            cur_idx,
  output logic [AW-1:0]            cur_step,
  output logic [AW-1:0]            cur_len,
  output logic [AW-1:0]            cur_start,
  input  logic                     hrd_en,
  input  logic                     hrd_bank,
  input  logic [$clog2(NSETS)-1:0] hrd_set,
  input  cag_field_e               hrd_field,
  output logic [AW-1:0]            hrd_data
);
  localparam int SW   = $clog2(NSETS);
  localparam int NENT = 2 * NSETS;
  localparam int EAW  = SW + 1;

  logic [AW-1:0] idx_q   [NENT];
  logic [AW-1:0] step_q  [NENT];
  logic [AW-1:0] len_q   [NENT];
  logic [AW-1:0] start_q [NENT];

  logic [EAW-1:0] wr_ent, upd_ent, cur_ent, hrd_ent;
  assign wr_ent  = {wr_bank,  wr_set};
  assign upd_ent = {upd_bank, upd_set};
  assign cur_ent = {cur_bank, cur_set};
  assign hrd_ent = {hrd_bank, hrd_set};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NENT; e++) begin
        idx_q[e]   <= '0;
        step_q[e]  <= '0;
        len_q[e]   <= '0;
        start_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NENT; e++) begin
        if (wr_en && wr_ent == EAW'(e) && wr_field == FLD_INDEX)
          idx_q[e] <= wr_data;
        else if (upd_en && upd_ent == EAW'(e))
          idx_q[e] <= upd_idx;
        if (wr_en && wr_ent == EAW'(e) && wr_field == FLD_STEP)
          step_q[e] <= wr_data;
        if (wr_en && wr_ent == EAW'(e) && wr_field == FLD_LENGTH)
          len_q[e] <= wr_data;
        if (wr_en && wr_ent == EAW'(e) && wr_field == FLD_START)
          start_q[e] <= wr_data;
      end
    end
  end

  assign cur_idx   = idx_q[cur_ent];
  assign cur_step  = step_q[cur_ent];
  assign cur_len   = len_q[cur_ent];
  assign cur_start = start_q[cur_ent];

  always_ff @(posedge clk) begin
    if (rst) begin
      hrd_data <= '0;
    end else if (hrd_en) begin
      case (hrd_field)
        FLD_INDEX:  hrd_data <= idx_q[hrd_ent];
        FLD_STEP:   hrd_data <= step_q[hrd_ent];
        FLD_LENGTH: hrd_data <= len_q[hrd_ent];
        default:    hrd_data <= start_q[hrd_ent];
      endcase
    end
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bank_sel,
  input  logic                     acc_req,
  input  logic [$clog2(NSETS)-1:0] acc_set,
  input  logic                     acc_pre,
  output logic [AW-1:0]            addr_out,
  output logic                     addr_valid,
  input  logic                     reg_wr_en,
  input  logic                     reg_rd_en,
  input  logic                     reg_bank,
  input  logic [$clog2(NSETS)-1:0] reg_set,
  input  logic [1:0]               reg_field,
  input  logic [AW-1:0]            reg_wdata,
  output logic [AW-1:0]            reg_rdata
);
  logic          bank_q;
  logic [AW-1:0] cur_idx, cur_step, cur_len, cur_start, folded, pre_addr;
  logic          upd_en;

  always_ff @(posedge clk) begin
    if (rst) bank_q <= 1'b0;
    else     bank_q <= bank_sel;
  end

  assign upd_en   = acc_req && !acc_pre;
  assign pre_addr = cur_idx + cur_step;

  cag_regfile #(.AW(AW), .NSETS(NSETS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_bank  (reg_bank),
    .wr_set   (reg_set),
    .wr_field (cag_field_e'(reg_field)),
    .wr_data  (reg_wdata),
    .upd_en   (upd_en),
    .upd_bank (bank_q),
    .upd_set  (acc_set),
    .upd_idx  (folded),
    .cur_bank (bank_q),
    .cur_set  (acc_set),
    .cur_idx  (cur_idx),
    .cur_step (cur_step),
    .cur_len  (cur_len),
    .cur_start(cur_start),
    .hrd_en   (reg_rd_en),
    .hrd_bank (reg_bank),
    .hrd_set  (reg_set),
    .hrd_field(cag_field_e'(reg_field)),
    .hrd_data (reg_rdata)
  );

  cag_fold #(.AW(AW)) u_fold (
    .idx  (cur_idx),
    .step (cur_step),
    .len  (cur_len),
    .start(cur_start),
    .nxt  (folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= acc_req;
      if (acc_req) addr_out <= acc_pre ? pre_addr : cur_idx;
    end
  end

  // Checks
  logic [AW:0] win_end;
  logic [AW-1:0] step_mag;
  logic        cur_inside, fold_inside;
  assign win_end     = {1'b0, cur_start} + {1'b0, cur_len};
  assign step_mag    = cur_step[AW-1] ? (~cur_step + 1'b1) : cur_step;
  assign cur_inside  = (cur_idx >= cur_start) && ({1'b0, cur_idx} < win_end);
  assign fold_inside = (folded  >= cur_start) && ({1'b0, folded}  < win_end);

  p_valid_tracks_req_r3: assert property (@(posedge clk) disable iff (rst)
    acc_req |=> addr_valid);
  p_idle_no_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_req |=> (!addr_valid && $stable(addr_out)));
  p_bank_registered_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bank_q == $past(bank_sel)));
  p_post_returns_index_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_pre) |=> (addr_out == $past(cur_idx)));
  p_pre_returns_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_pre) |=> (addr_out == $past(cur_idx) + $past(cur_step)));
  p_fold_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && cur_len != '0 && cur_inside && step_mag <= cur_len) |-> fold_inside);
endmodule

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;
  localparam int AW = 32;
  localparam int NSETS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bank_sel = 1'b0, acc_req = 1'b0, acc_pre = 1'b0;
  logic [2:0] acc_set = '0;
  logic [AW-1:0] addr_out;
  logic addr_valid;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0, reg_bank = 1'b0;
  logic [2:0] reg_set = '0;
  logic [1:0] reg_field = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  circ_addr_gen #(.AW(AW), .NSETS(NSETS)) i_circ_addr_gen (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .acc_req(acc_req),
    .acc_set(acc_set), .acc_pre(acc_pre), .addr_out(addr_out),
    .addr_valid(addr_valid), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_bank(reg_bank), .reg_set(reg_set), .reg_field(reg_field),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bank, input int set, input int fld, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_bank = bank; reg_set = 3'(set); reg_field = 2'(fld); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic bank, input int set, input int fld,
                          input logic [AW-1:0] exp);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_bank = bank; reg_set = 3'(set); reg_field = 2'(fld);
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  task automatic setup(input logic bank, input int set, input logic [AW-1:0] st,
                       input logic [AW-1:0] ln, input logic [AW-1:0] sp, input logic [AW-1:0] ix);
    wr(bank, set, 3, st);
    wr(bank, set, 2, ln);
    wr(bank, set, 1, sp);
    wr(bank, set, 0, ix);
  endtask

  // one access, check returned address and valid one cycle later
  task automatic access(input string req, input int set, input logic pre, input logic [AW-1:0] exp);
    @(negedge clk);
    acc_req = 1'b1; acc_set = 3'(set); acc_pre = pre;
    @(negedge clk);
    acc_req = 1'b0;
    check(req, addr_out, exp);
    check(req, {31'b0, addr_valid}, 32'd1);
  endtask

  task automatic t_reset;
    check("R1", {31'b0, addr_valid}, 32'd0);
    check("R1", addr_out, '0);
    check("R1", reg_rdata, '0);
    for (int f = 0; f < 4; f++) begin
      rd_check("R1", 1'b0, 0, f, '0);
      rd_check("R1", 1'b1, 7, f, '0);
    end
  endtask

  task automatic t_regport;
    setup(1'b0, 2, 32'hDEAD_0001, 32'h0000_0123, 32'h0000_0004, 32'hDEAD_0010);
    rd_check("R2", 1'b0, 2, 3, 32'hDEAD_0001);
    rd_check("R2", 1'b0, 2, 2, 32'h0000_0123);
    rd_check("R2", 1'b0, 2, 1, 32'h0000_0004);
    rd_check("R2", 1'b0, 2, 0, 32'hDEAD_0010);
    rd_check("R2", 1'b1, 2, 0, 32'h0);
  endtask

  task automatic t_wrap_up;
    // unaligned start 0x1003, length 10, step 3
    setup(1'b0, 1, 32'h1003, 32'd10, 32'd3, 32'h1003);
    access("R3", 1, 1'b0, 32'h1003);
    access("R3", 1, 1'b0, 32'h1006);
    access("R11", 1, 1'b0, 32'h1009);
    access("R5", 1, 1'b0, 32'h100C);
    access("R5", 1, 1'b0, 32'h1005);
    rd_check("R5", 1'b0, 1, 0, 32'h1008);
  endtask

  task automatic t_wrap_down;
    setup(1'b0, 3, 32'h200, 32'd8, 32'hFFFF_FFFD, 32'h201);
    access("R6", 3, 1'b0, 32'h201);
    access("R6", 3, 1'b0, 32'h206);
    access("R6", 3, 1'b0, 32'h203);
    rd_check("R6", 1'b0, 3, 0, 32'h200);
  endtask

  task automatic t_pre;
    setup(1'b0, 4, 32'h40, 32'd16, 32'd5, 32'h44);
    access("R4", 4, 1'b1, 32'h49);
    access("R4", 4, 1'b1, 32'h49);
    rd_check("R4", 1'b0, 4, 0, 32'h44);
  endtask

  task automatic t_linear;
    setup(1'b0, 5, 32'h0, 32'd0, 32'd3, 32'hFFFF_FFFE);
    access("R7", 5, 1'b0, 32'hFFFF_FFFE);
    access("R7", 5, 1'b0, 32'h1);
    rd_check("R7", 1'b0, 5, 0, 32'h4);
  endtask

  task automatic t_bank;
    setup(1'b1, 0, 32'h0, 32'd0, 32'd1, 32'h7000);
    // select raised with the first access: that access still uses primary set 0
    @(negedge clk);
    bank_sel = 1'b1; acc_req = 1'b1; acc_set = 3'd0; acc_pre = 1'b0;
    @(negedge clk);
    acc_req = 1'b0;
    check("R8", addr_out, 32'h0);
    access("R8", 0, 1'b0, 32'h7000);
    access("R8", 0, 1'b0, 32'h7001);
    @(negedge clk);
    bank_sel = 1'b0;
    rd_check("R8", 1'b1, 0, 0, 32'h7002);
    rd_check("R8", 1'b0, 0, 0, 32'h0);
  endtask

  task automatic t_collide;
    setup(1'b0, 6, 32'h0, 32'd0, 32'd1, 32'h10);
    @(negedge clk);
    acc_req = 1'b1; acc_set = 3'd6; acc_pre = 1'b0;
    reg_wr_en = 1'b1; reg_bank = 1'b0; reg_set = 3'd6; reg_field = 2'd0; reg_wdata = 32'h500;
    @(negedge clk);
    acc_req = 1'b0; reg_wr_en = 1'b0;
    check("R9", addr_out, 32'h10);
    rd_check("R9", 1'b0, 6, 0, 32'h500);
  endtask

  task automatic t_idle;
    access("R10", 6, 1'b0, 32'h500);
    repeat (3) begin
      @(negedge clk);
      check("R10", {31'b0, addr_valid}, 32'd0);
      check("R10", addr_out, 32'h500);
    end
    rd_check("R10", 1'b0, 6, 0, 32'h501);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regport();
    t_wrap_up();
    t_wrap_down();
    t_pre();
    t_linear();
    t_bank();
    t_collide();
    t_idle();
    finished = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      report();
    end
  end
endmodule